// File: doc/BRIEF.md
# Calendar Real-Time Clock with Posted Register Writes

This block is a calendar counter for a chip's always-on timekeeping. It holds seconds, minutes, hours, day of month, month, a year offset and a leap-year flag. It advances once per pulse on a one-pulse-per-second tick input. Software reaches it through a small 32-bit register bus. There are three registers: a control word, a packed date word and a packed time word.

Writes to the time or date word are posted. The written value waits in a holding slot for a fixed number of system clocks and only then replaces the running count. While the value waits, a busy bit for that register reads as 1 in the control word, and software polls that bit before it trusts the readback. Reads always return the live count.

The year field width is a parameter. With the default of 8 bits the leap flag sits at bit 24. With 6 bits it sits at bit 22. The leap flag is never computed by the block. Software writes it, and it decides only how long February is.

Top module: `rtc_calendar`

## Requirements
- R1: After synchronous reset the control word reads 0, the time word reads 0, and the date word reads 0x00000101 (day 1, month 1, year 0, leap flag clear).
- R2: Registers sit at byte addresses 0x0 (control), 0x4 (date) and 0x8 (time); any other address reads 0. In the control word, bit 8 is the time-busy bit and bit 7 is the date-busy bit, and all other control bits read 0.
- R3: The time word carries seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. The date word carries the day in bits 4:0, the month (1..12) in bits 11:8, the year in bits 16 upward (YEAR_W bits), and the leap flag at bit 16+YEAR_W. Bits outside these fields read 0.
- R4: Each write to the time or date register sets that register's busy bit from the next clock. The busy bit stays set for exactly COMMIT_DLY clocks (default 4). At the clock that clears it, the written fields are loaded exactly as written. Until then, readback shows the old value.
- R5: A second write to a register whose busy bit is set replaces the pending value and restarts the full COMMIT_DLY delay.
- R6: An all-zero write to time or date is posted, tracked by its busy bit and loaded like any other value.
- R7: On each tick, seconds count up and wrap from 59 to 0 with a carry into minutes. Minutes wrap from 59 to 0 with a carry into hours. Hours wrap from 23 to 0 with a carry into the date.
- R8: A date carry on the last day of the month sets the day to 1 and advances the month. Months 1, 3, 5, 7, 8, 10 and 12 have 31 days, and months 4, 6, 9 and 11 have 30. February has 29 days when the leap flag is 1 and 28 when it is 0.
- R9: A date carry on day 31 of month 12 sets the month to 1 and adds one to the year modulo 2^YEAR_W. The leap flag stays as written.
- R10: While a register's busy bit is set, ticks and date carries do not change that register. A time wrap at midnight that occurs while the date is busy is lost to the date.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, once per second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
Two events can fall in the same cycle: a pending commit and a tick, or a midnight carry arriving while the date write is still waiting. The bench provokes both. It pulses the tick right after a time write, and it writes the date just before a tick that rolls the time past 23:59:59. It then expects the committed words to equal the written values exactly. A rewrite during the busy window is timed so that the first write would have committed, and the bench checks the busy bit and the old readback at that cycle. Month-end rollover is swept over all twelve months with both leap settings and a year at its top value.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam logic [3:0] ADDR_CTRL = 4'h0;
    localparam logic [3:0] ADDR_DATE = 4'h4;
    localparam logic [3:0] ADDR_TIME = 4'h8;

    localparam int BUSY_TIME_BIT = 8;
    localparam int BUSY_DATE_BIT = 7;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;

    typedef struct packed {
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } hms_t;

    localparam int HMS_W = $bits(hms_t);

    function automatic logic [31:0] pack_time(hms_t t);
        logic [31:0] w;
        w        = '0;
        w[5:0]   = t.sec;
        w[13:8]  = t.min;
        w[20:16] = t.hour;
        return w;
    endfunction

    function automatic hms_t unpack_time(logic [31:0] w);
        hms_t t;
        t.sec  = w[5:0];
        t.min  = w[13:8];
        t.hour = w[20:16];
        return t;
    endfunction

    function automatic logic [DAY_W-1:0] month_len(logic [MON_W-1:0] m, logic leap);
        logic [DAY_W-1:0] n;
        case (m)
            4'd2:                      n = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   n = 5'd30;
            default:                   n = 5'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_commit_slot.sv
module rtc_commit_slot #(
    parameter int W   = 17,
    parameter int DLY = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         busy,
    output logic         load,
    output logic [W-1:0] ldata
);
    localparam int CNT_W = $clog2(DLY + 1);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(DLY);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            ldata <= '0;
        end else if (wr) begin
            busy  <= 1'b1;
            cnt   <= CNT_INIT;
            ldata <= wdata;
        end else if (busy) begin
            if (cnt == CNT_W'(1)) busy <= 1'b0;
            else                  cnt  <= cnt - 1'b1;
        end
    end

    assign load = busy && (cnt == CNT_W'(1)) && !wr;

    AST_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr |=> busy);  // R4
    AST_LOAD_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        load |=> !busy);  // R4
    AST_REWRITE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr |=> !load || (DLY == 1));  // R5

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hold,
    input  logic load,
    input  hms_t ldata,
    output hms_t hms,
    output logic day_carry
);
    hms_t nxt;
    logic sec_wrap, min_wrap, hour_wrap, adv;

    assign adv       = tick && !hold && !load;
    assign sec_wrap  = hms.sec  >= SEC_W'(59);
    assign min_wrap  = hms.min  >= MIN_W'(59);
    assign hour_wrap = hms.hour >= HOUR_W'(23);

    always_comb begin
        nxt = hms;
        if (!sec_wrap) begin
            nxt.sec = hms.sec + 1'b1;
        end else begin
            nxt.sec = '0;
            if (!min_wrap) begin
                nxt.min = hms.min + 1'b1;
            end else begin
                nxt.min  = '0;
                nxt.hour = hour_wrap ? '0 : hms.hour + 1'b1;
            end
        end
    end

    assign day_carry = adv && sec_wrap && min_wrap && hour_wrap;

    always_ff @(posedge clk) begin
        if (rst)       hms <= '0;
        else if (load) hms <= ldata;
        else if (adv)  hms <= nxt;
    end

    AST_TIME_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hold && !load) |=> $stable(hms));  // R10
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold && !load && hms.sec == 6'd59) |=> (hms.sec == 6'd0));  // R7
    AST_TIME_LOAD_EXACT: assert property (@(posedge clk) disable iff (rst)
        load |=> (hms == $past(ldata)));  // R4

endmodule

// File: rtl/rtc_date_counter.sv
module rtc_date_counter
    import rtc_cal_pkg::*;
#(
    parameter int YEAR_W = 8,
    localparam int DW    = 1 + YEAR_W + MON_W + DAY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          carry,
    input  logic          hold,
    input  logic          load,
    input  logic [DW-1:0] ldata,
    output logic [DW-1:0] date_q
);
    logic              leap;
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  month;
    logic [DAY_W-1:0]  day;
    logic [DW-1:0]     nxt;
    logic              adv;

    assign {leap, year, month, day} = date_q;
    assign adv = carry && !hold && !load;

    always_comb begin
        if (day < month_len(month, leap)) begin
            nxt = {leap, year, month, day + 1'b1};
        end else if (month < MON_W'(12)) begin
            nxt = {leap, year, month + 1'b1, DAY_W'(1)};
        end else begin
            nxt = {leap, year + 1'b1, MON_W'(1), DAY_W'(1)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       date_q <= {1'b0, {YEAR_W{1'b0}}, MON_W'(1), DAY_W'(1)};
        else if (load) date_q <= ldata;
        else if (adv)  date_q <= nxt;
    end

    AST_DATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hold && !load) |=> $stable(date_q));  // R10
    AST_YEAR_ROLL: assert property (@(posedge clk) disable iff (rst)
        (adv && month == 4'd12 && day >= 5'd31) |=>
            (month == 4'd1 && day == 5'd1 && year == YEAR_W'($past(year) + 1'b1)));  // R9
    AST_LEAP_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!load) |=> $stable(leap));  // R9

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int YEAR_W    = 8,
    parameter int COMMIT_DLY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam int LEAP_POS = 16 + YEAR_W;
    localparam int DW       = 1 + YEAR_W + MON_W + DAY_W;

    logic wr_time, wr_date;
    logic time_busy, time_load, date_busy, date_load, day_carry;
    hms_t time_pend, time_cur;
    logic [DW-1:0] date_wr, date_pend, date_cur;
    logic unused_wbits;

    assign wr_time = reg_wr && (reg_addr == ADDR_W'(ADDR_TIME));
    assign wr_date = reg_wr && (reg_addr == ADDR_W'(ADDR_DATE));
    assign date_wr = {reg_wdata[LEAP_POS], reg_wdata[16 +: YEAR_W],
                      reg_wdata[11:8], reg_wdata[4:0]};
    assign unused_wbits = ^{reg_wdata[31:LEAP_POS+1], reg_wdata[15:14], reg_wdata[7:6]};

    rtc_commit_slot #(.W(HMS_W), .DLY(COMMIT_DLY)) i_time_slot (
        .clk(clk), .rst(rst), .wr(wr_time), .wdata(unpack_time(reg_wdata)),
        .busy(time_busy), .load(time_load), .ldata(time_pend));

    rtc_commit_slot #(.W(DW), .DLY(COMMIT_DLY)) i_date_slot (
        .clk(clk), .rst(rst), .wr(wr_date), .wdata(date_wr),
        .busy(date_busy), .load(date_load), .ldata(date_pend));

    rtc_time_counter i_time (
        .clk(clk), .rst(rst), .tick(tick), .hold(time_busy), .load(time_load),
        .ldata(time_pend), .hms(time_cur), .day_carry(day_carry));

    rtc_date_counter #(.YEAR_W(YEAR_W)) i_date (
        .clk(clk), .rst(rst), .carry(day_carry), .hold(date_busy), .load(date_load),
        .ldata(date_pend), .date_q(date_cur));

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata[BUSY_TIME_BIT] = time_busy;
            reg_rdata[BUSY_DATE_BIT] = date_busy;
        end else if (reg_addr == ADDR_W'(ADDR_TIME)) begin
            reg_rdata = pack_time(time_cur);
        end else if (reg_addr == ADDR_W'(ADDR_DATE)) begin
            reg_rdata[4:0]           = date_cur[DAY_W-1:0];
            reg_rdata[11:8]          = date_cur[DAY_W +: MON_W];
            reg_rdata[16 +: YEAR_W]  = date_cur[DAY_W+MON_W +: YEAR_W];
            reg_rdata[LEAP_POS]      = date_cur[DW-1];
        end
    end

    AST_CTRL_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(ADDR_CTRL)) |->
            ((reg_rdata & ~32'h0000_0180) == 32'h0));  // R2
    AST_DATE_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(ADDR_DATE)) |->
            (reg_rdata[15:12] == 4'h0 && reg_rdata[7:5] == 3'h0));  // R3

endmodule

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;
    localparam int DLY    = 4;
    localparam int YEAR_W = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    rtc_calendar #(.ADDR_W(4), .YEAR_W(YEAR_W), .COMMIT_DLY(DLY)) i_rtc_calendar (
        .clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    function automatic int mlen(int m, int lp);
        if (m == 2) return lp ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] tword(int h, int m, int s);
        return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
    endfunction

    function automatic logic [31:0] dword(int d, int m, int y, int lp);
        return (32'(lp) << (16 + YEAR_W)) | (32'(y) << 16) | (32'(m) << 8) | 32'(d);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic settle;
        repeat (DLY + 1) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v); check("R1 ctrl", v, 32'h0);
        rd(4'h8, v); check("R1 time", v, 32'h0);
        rd(4'h4, v); check("R1 date", v, 32'h0000_0101);
        rd(4'hC, v); check("R2 unmapped", v, 32'h0);

        // R3 field layout, R4 posted timing
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R4 time busy", v, 32'h100);
        repeat (DLY - 1) @(negedge clk);
        rd(4'h0, v); check("R4 busy at last cycle", v, 32'h100);
        rd(4'h8, v); check("R4 old value while busy", v, 32'h0);
        @(negedge clk);
        rd(4'h0, v); check("R4 busy cleared", v, 32'h0);
        rd(4'h8, v); check("R3 time fields", v, 32'h001F_3F3F);
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R4 date busy", v, 32'h080);
        settle();
        rd(4'h4, v); check("R3 date fields", v, 32'h01FF_0F1F);

        // R6 zero writes, both pending together (R2)
        wr(4'h8, 32'h0);
        wr(4'h4, 32'h0);
        rd(4'h0, v); check("R2 both busy", v, 32'h180);
        settle();
        rd(4'h8, v); check("R6 time zero", v, 32'h0);
        rd(4'h4, v); check("R6 date zero", v, 32'h0);

        // R5 rewrite restarts delay
        wr(4'h8, tword(1, 2, 3));
        repeat (2) @(negedge clk);
        wr(4'h8, tword(4, 5, 6));
        repeat (DLY - 1) @(negedge clk);
        rd(4'h0, v); check("R5 still busy", v, 32'h100);
        rd(4'h8, v); check("R5 first value not loaded", v, 32'h0);
        @(negedge clk);
        rd(4'h8, v); check("R5 replacement loaded", v, tword(4, 5, 6));

        // R10 tick during pending time commit
        wr(4'h8, tword(10, 11, 12));
        pulse();
        settle();
        rd(4'h8, v); check("R10 time exact after tick", v, tword(10, 11, 12));

        // R10 midnight carry lost while date busy
        wr(4'h8, tword(23, 59, 59));
        settle();
        wr(4'h4, dword(10, 4, 7, 0));
        pulse();
        rd(4'h8, v); check("R7 midnight wrap", v, 32'h0);
        settle();
        rd(4'h4, v); check("R10 date exact after carry", v, dword(10, 4, 7, 0));

        // R7 tick sweep across midnight
        wr(4'h8, tword(23, 0, 0));
        wr(4'h4, dword(5, 3, 10, 0));
        settle();
        for (int n = 1; n <= 3700; n++) begin
            int t;
            pulse();
            t = (82800 + n) % 86400;
            rd(4'h8, v);
            check("R7 time count", v, tword(t / 3600, (t / 60) % 60, t % 60));
        end
        rd(4'h4, v); check("R7 day carry", v, dword(6, 3, 10, 0));

        // R8/R9 month-end sweep
        for (int yi = 0; yi < 2; yi++) begin
            for (int m = 1; m <= 12; m++) begin
                for (int lp = 0; lp < 2; lp++) begin
                    int y, ln, nm, ny;
                    y  = (yi == 0) ? 5 : 255;
                    ln = mlen(m, lp);
                    nm = (m == 12) ? 1 : m + 1;
                    ny = (m == 12) ? (y + 1) % 256 : y;
                    wr(4'h4, dword(ln - 1, m, y, lp));
                    wr(4'h8, tword(23, 59, 59));
                    settle();
                    pulse();
                    rd(4'h4, v); check("R8 last day reached", v, dword(ln, m, y, lp));
                    wr(4'h8, tword(23, 59, 59));
                    settle();
                    pulse();
                    rd(4'h4, v);
                    if (m == 12) check("R9 year rollover", v, dword(1, nm, ny, lp));
                    else         check("R8 month rollover", v, dword(1, nm, ny, lp));
                end
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule